// File: doc/BRIEF.md
# Select-Line Command Packet Receiver

This block listens to the two select bits that software writes into the joypad port and treats the sequence of values as a serial command channel. A "00" symbol opens a new frame and empties the packet store. Each "01" or "10" symbol sets or leaves the current bit. Each following "11" symbol moves to the next bit. After all bits of a packet have been clocked in, a change to "10" hands the whole packet downstream with a one-cycle strobe.

The same symbol stream also steps a multiplayer controller index. A transition from a symbol whose upper bit is set down to "00" or "01" arms an internal step flag. The next change to "11" consumes the flag and advances the index, wrapped by a controller-count mask that software supplies. Downstream logic reads the packet bus after the strobe. It uses the controller index to choose which pad's keys to return.

Top module: `jp_cmd_rx`

## Requirements
- R1: After reset the packet bus is all zeros, the strobe is low, the controller index is 0, the remembered previous symbol is 11 (so a first written 11 is a repeat) and the bit index is idle, so a 01 written before any 11 sets no bit.
- R2: Every written 00 symbol, repeated or not, clears the whole packet store to zero and returns the bit index to idle.
- R3: Apart from 00, a written symbol equal to the previous one has no effect on the bit index, the packet store, the step flag or the controller index.
- R4: A change to 01 while the bit index is k (0 to PKT_BITS-1, not idle) sets packet bit k, which is bit k%8 of byte k/8 with byte 0 in packet[7:0]. A change to 10 leaves the store unchanged.
- R5: A change to 11 advances the bit index by one; from idle it moves to 0.
- R6: When the bit index equals PKT_BITS and the symbol changes to 10, the strobe packet_valid is high for exactly one cycle, starting in the cycle after the write. The index then moves beyond PKT_BITS.
- R7: A change to 00 or 01 from a previous symbol of 10 or 11 toggles the step flag.
- R8: A change to 11 while the step flag is set clears the flag and sets the controller index to (index + 1) AND ctrl_mask. Changes to 11 with the flag clear leave the index unchanged.
- R9: After a delivery, no symbol other than 00 alters the packet bus or produces another strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_wr | input | 1 | Strobe: software wrote the joypad select bits this cycle |
| sel_val | input | 2 | Written select symbol (register bits 5:4) |
| ctrl_mask | input | CTRL_W | Controller-count mask applied when the index steps |
| packet | output | PKT_BITS | Assembled packet, byte 0 in the low bits, LSB first |
| packet_valid | output | 1 | One-cycle strobe: packet complete |
| ctrl_idx | output | CTRL_W | Current controller index |

## Verification
The bench builds the receiver with PKT_BITS at its default of 128 and CTRL_W widened to 3. The wider mask brings an eight-way wrap of the controller index within reach, alongside the usual masks of one, two and four players and a zero mask that pins the index. Full 128-bit frames drive the index all the way to the delivery point, so the frozen state after delivery and the top byte of the store are both exercised. Clears in mid-frame and repeated symbols are mixed in, and a reference model inside the bench predicts every packet, strobe and controller value.

// File: rtl/jp_cmd_pkg.sv
package jp_cmd_pkg;

    // Symbol encodings carried on the two select lines.
    typedef enum logic [1:0] {
        SYM_RESET = 2'b00,
        SYM_ONE   = 2'b01,
        SYM_ZERO  = 2'b10,
        SYM_CLOCK = 2'b11
    } jp_sym_e;

    // Value the previous-symbol register holds out of reset.
    localparam logic [1:0] SYM_AT_RESET = SYM_CLOCK;

    function automatic logic is_low_pair(input logic [1:0] s);
        return (s == SYM_RESET) || (s == SYM_ONE);
    endfunction

endpackage

// File: rtl/jp_sym_tracker.sv
module jp_sym_tracker
    import jp_cmd_pkg::*;
#(
    parameter int CTRL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        sym,
    input  logic [CTRL_W-1:0] mask,
    output logic              sym_change,
    output logic [CTRL_W-1:0] ctrl_idx
);

    typedef struct packed {
        logic [1:0]        prev;
        logic              step;
        logic [CTRL_W-1:0] ctrl;
    } trk_t;

    localparam logic [CTRL_W-1:0] CTRL_ONE = CTRL_W'(1);

    trk_t st_q, st_d;

    assign sym_change = wr_en && (sym != st_q.prev);
    assign ctrl_idx   = st_q.ctrl;

    always_comb begin
        st_d = st_q;
        if (sym_change) begin
            if (is_low_pair(sym)) begin
                if (st_q.prev[1]) begin
                    st_d.step = ~st_q.step;
                end
            end else if (sym == SYM_CLOCK) begin
                if (st_q.step) begin
                    st_d.step = 1'b0;
                    st_d.ctrl = (st_q.ctrl + CTRL_ONE) & mask;
                end
            end
            st_d.prev = sym;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= SYM_AT_RESET;
            st_q.step <= 1'b0;
            st_q.ctrl <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_REPEAT_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sym == st_q.prev) |=> $stable(ctrl_idx)); // R3

    AST_CTRL_MOVES_ON_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_idx) |-> $past(wr_en && sym == SYM_CLOCK)); // R8

    AST_CTRL_WITHIN_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_idx) |-> ((ctrl_idx & ~$past(mask)) == '0)); // R8

endmodule

// File: rtl/jp_bit_framer.sv
module jp_bit_framer
    import jp_cmd_pkg::*;
#(
    parameter int PKT_BITS = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          sym,
    input  logic                sym_change,
    output logic [PKT_BITS-1:0] bits,
    output logic                valid
);

    localparam int IDX_W = $clog2(PKT_BITS + 2);
    localparam int POS_W = (PKT_BITS > 1) ? $clog2(PKT_BITS) : 1;
    localparam logic [IDX_W-1:0] FULL_IDX = IDX_W'(PKT_BITS);
    localparam logic [IDX_W-1:0] LOCK_IDX = IDX_W'(PKT_BITS + 1);
    localparam logic [IDX_W-1:0] IDX_ONE  = IDX_W'(1);

    typedef struct packed {
        logic                idle;
        logic [IDX_W-1:0]    idx;
        logic [PKT_BITS-1:0] bits;
        logic                valid;
    } frm_t;

    frm_t st_q, st_d;

    assign bits  = st_q.bits;
    assign valid = st_q.valid;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (wr_en && sym == SYM_RESET) begin
            st_d.idle = 1'b1;
            st_d.idx  = '0;
            st_d.bits = '0;
        end
        if (sym_change) begin
            if (!st_d.idle && st_d.idx == FULL_IDX && sym == SYM_ZERO) begin
                st_d.valid = 1'b1;
                st_d.idx   = LOCK_IDX;
            end
            if (st_d.idle || st_d.idx < FULL_IDX) begin
                if (sym == SYM_ONE) begin
                    if (!st_d.idle) begin
                        st_d.bits[st_d.idx[POS_W-1:0]] = 1'b1;
                    end
                end else if (sym == SYM_CLOCK) begin
                    if (st_d.idle) begin
                        st_d.idle = 1'b0;
                        st_d.idx  = '0;
                    end else begin
                        st_d.idx = st_d.idx + IDX_ONE;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.idle  <= 1'b1;
            st_q.idx   <= '0;
            st_q.bits  <= '0;
            st_q.valid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R6

    AST_STROBE_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (!st_q.idle && st_q.idx == LOCK_IDX)); // R6

    AST_RESET_SYMBOL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sym == SYM_RESET) |=> (bits == '0 && st_q.idle)); // R2

    AST_LOCKED_STORE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.idle && st_q.idx == LOCK_IDX && !(wr_en && sym == SYM_RESET)) |=> $stable(bits)); // R9

    AST_REPEAT_KEEPS_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sym_change && sym != SYM_RESET) |=> $stable(bits)); // R3

endmodule

// File: rtl/jp_cmd_rx.sv
module jp_cmd_rx
    import jp_cmd_pkg::*;
#(
    parameter int PKT_BITS = 128,
    parameter int CTRL_W   = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel_wr,
    input  logic [1:0]          sel_val,
    input  logic [CTRL_W-1:0]   ctrl_mask,
    output logic [PKT_BITS-1:0] packet,
    output logic                packet_valid,
    output logic [CTRL_W-1:0]   ctrl_idx
);

    logic sym_change;

    jp_sym_tracker #(
        .CTRL_W (CTRL_W)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sel_wr),
        .sym        (sel_val),
        .mask       (ctrl_mask),
        .sym_change (sym_change),
        .ctrl_idx   (ctrl_idx)
    );

    jp_bit_framer #(
        .PKT_BITS (PKT_BITS)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (sel_wr),
        .sym        (sel_val),
        .sym_change (sym_change),
        .bits       (packet),
        .valid      (packet_valid)
    );

endmodule

// File: tb/tb_jp_cmd_rx.sv
module tb_jp_cmd_rx;

    localparam int PKT    = 128;
    localparam int CW     = 3;
    localparam int CLK_NS = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           sel_wr = 1'b0;
    logic [1:0]     sel_val = 2'b00;
    logic [CW-1:0]  ctrl_mask = '1;
    logic [PKT-1:0] packet;
    logic           packet_valid;
    logic [CW-1:0]  ctrl_idx;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference model state
    logic [1:0]     m_prev = 2'b11;
    int             m_idx  = -1;
    logic [PKT-1:0] m_buf  = '0;
    logic           m_step = 1'b0;
    logic [CW-1:0]  m_ctrl = '0;

    logic [PKT-1:0] exp_q[$];
    int             seen = 0;
    int             pushed = 0;

    always #(CLK_NS/2) clk = ~clk;

    jp_cmd_rx #(.PKT_BITS(PKT), .CTRL_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_val(sel_val),
        .ctrl_mask(ctrl_mask), .packet(packet), .packet_valid(packet_valid),
        .ctrl_idx(ctrl_idx)
    );

    task automatic chk(input bit ok, input string req, input logic [PKT-1:0] act, input logic [PKT-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected packets as strobes appear
    always @(negedge clk) begin
        if (rst_n && packet_valid) begin
            seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected strobe", packet, '0);
            end else begin
                logic [PKT-1:0] e;
                e = exp_q.pop_front();
                chk(packet == e, "R6 delivered packet", packet, e);
            end
        end
    end

    task automatic model(input logic [1:0] s);
        if (s == 2'b00) begin
            m_idx = -1;
            m_buf = '0;
        end
        if (s != m_prev) begin
            if (s == 2'b00 || s == 2'b01) begin
                if (m_prev[1]) m_step = ~m_step;
            end else if (s == 2'b11) begin
                if (m_step) begin
                    m_step = 1'b0;
                    m_ctrl = (m_ctrl + 1'b1) & ctrl_mask;
                end
            end
            m_prev = s;
            if (m_idx == PKT && s == 2'b10) begin
                exp_q.push_back(m_buf);
                pushed++;
                m_idx++;
            end
            if (m_idx < PKT) begin
                if (s == 2'b01 && m_idx >= 0) m_buf[m_idx] = 1'b1;
                else if (s == 2'b11) m_idx++;
            end
        end
    endtask

    // driver: writes one symbol, then compares ports with the model
    task automatic send(input logic [1:0] s, input string req);
        model(s);
        @(negedge clk);
        sel_wr  = 1'b1;
        sel_val = s;
        @(negedge clk);
        sel_wr  = 1'b0;
        chk(packet == m_buf, req, packet, m_buf);
        chk(ctrl_idx == m_ctrl, req, PKT'(ctrl_idx), PKT'(m_ctrl));
    endtask

    task automatic send_frame(input logic [PKT-1:0] data, input string req);
        send(2'b00, req);
        send(2'b11, req);
        for (int i = 0; i < PKT; i++) begin
            send(data[i] ? 2'b01 : 2'b10, req);
            send(2'b11, req);
        end
        send(2'b10, req);
    endtask

    task automatic finish_up();
        chk(exp_q.size() == 0 && seen == pushed, "R6 strobe count", PKT'(seen), PKT'(pushed));
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", '0, '0);
            finish_up();
        end
    end

    initial begin
        logic [PKT-1:0] pa, pb, hold;
        pa = {32'hDEADBEEF, 32'h0123_4567, 32'h89AB_CDEF, 32'h8000_00A5};
        pb = {PKT{1'b1}};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(packet == '0, "R1 packet", packet, '0);
        chk(packet_valid == 1'b0, "R1 strobe", PKT'(packet_valid), '0);
        chk(ctrl_idx == '0, "R1 ctrl", PKT'(ctrl_idx), '0);
        // R1 first 11 is a repeat, idle index: a 01 sets nothing
        send(2'b11, "R1 first clock repeat");
        send(2'b01, "R1 idle one");
        chk(packet == '0, "R1 idle sets no bit", packet, '0);

        // R4 R5 single-bit placement: bit 0 and bit 9
        send(2'b00, "R2 open");
        send(2'b11, "R5 idle to zero");
        send(2'b01, "R4 bit0");
        chk(packet == PKT'(1), "R4 bit0 set", packet, PKT'(1));
        send(2'b11, "R5 advance");
        for (int i = 1; i < 9; i++) begin
            send(2'b10, "R4 zero");
            send(2'b11, "R5 advance");
        end
        send(2'b01, "R4 bit9");
        chk(packet == PKT'(12'h201), "R4 byte1 bit1", packet, PKT'(12'h201));
        // R3 repeats ignored
        send(2'b01, "R3 repeat one");
        send(2'b11, "R5 advance");
        send(2'b11, "R3 repeat clock");
        send(2'b01, "R4 bit10");
        chk(packet == PKT'(12'h601), "R3 one advance only", packet, PKT'(12'h601));
        // R2 double clear mid-frame
        send(2'b00, "R2 clear");
        chk(packet == '0, "R2 cleared", packet, '0);
        send(2'b00, "R2 repeated clear");
        chk(packet == '0, "R2 cleared again", packet, '0);

        // full frames R6
        ctrl_mask = 3'b011;
        send_frame(pa, "R6 frame A");
        hold = packet;
        chk(hold == pa, "R6 frame A content", hold, pa);
        // R9 locked after delivery
        send(2'b01, "R9 locked one");
        send(2'b11, "R9 locked clock");
        send(2'b10, "R9 no second strobe");
        chk(packet == hold, "R9 held", packet, hold);
        send_frame(pb, "R6 frame B all ones");
        send_frame('0, "R6 frame zeros");

        // R7 R8 controller stepping with various masks
        ctrl_mask = 3'b111;
        for (int i = 0; i < 10; i++) begin
            send(2'b01, "R7 arm");
            send(2'b11, "R8 step mask7");
        end
        ctrl_mask = 3'b001;
        for (int i = 0; i < 3; i++) begin
            send(2'b00, "R7 arm via 00");
            send(2'b11, "R8 step mask1");
        end
        // R7 double toggle cancels: 11->01->10->01 toggles twice
        send(2'b01, "R7 arm");
        send(2'b10, "R7 none");
        send(2'b01, "R7 disarm");
        send(2'b11, "R8 no step");
        ctrl_mask = 3'b000;
        send(2'b01, "R7 arm");
        send(2'b11, "R8 mask zero");
        chk(ctrl_idx == '0, "R8 mask zero pins", PKT'(ctrl_idx), '0);
        ctrl_mask = 3'b011;
        send_frame(pa ^ pb, "R6 frame C");
        repeat (3) @(negedge clk);
        done = 1;
        finish_up();
    end

endmodule